// File: doc/BRIEF.md
# Descriptor-Chaining DMA Channel Sequencer

This block is the control sequencer of a single DMA channel. It owns the channel's run state and decides which segment moves next. It has no data path and does not split bursts. Those jobs belong to a segment engine that sits beside it. The sequencer drives the segment's addresses, remaining count and snoop flag to that engine, and the engine reports each committed beat back with its size in bytes.

The channel has two modes, and a rising edge on the channel-start input launches either one.

- **Direct mode** runs one segment taken from the configuration inputs.
- **Chaining mode** reads 4-word descriptors through a simple memory read port and runs one segment per descriptor. It follows the next pointers until it reaches a descriptor marked last.

Two events halt the channel: clearing channel-start, or a pulse on the error input. After a halt, software can resume the interrupted transfer or launch a new one.

Descriptor layout, as word offsets from a 32-byte aligned descriptor base:

| Offset | Content |
|---|---|
| +0 | source address |
| +4 | destination address |
| +8 | next pointer |
| +12 | byte count, in the low CW bits |

In the next pointer, bit 0 marks the current descriptor as last. Bit 1 is the snoop flag of the descriptor that the pointer leads to. Bits 4:2 are ignored.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is held, and until the first start, busy, done, error, rd_req and seg_run are all 0.
- R2: A 0-to-1 change of `start` launches the channel. In direct mode, seg_run rises one clock later with seg_src, seg_dst and seg_rem equal to cfg_src, cfg_dst and cfg_count. In chaining mode, rd_req rises one clock later with rd_addr equal to cfg_desc_ptr with bits 4:0 cleared.
- R3: A transfer completes, with done set and busy cleared, exactly when the accepted beat sizes add up to the byte count. A direct launch with a count of 0 sets done one clock after the launch and never raises seg_run.
- R4: A descriptor is read as four words at base+0, +4, +8 and +12, in that order. The word at +0 is the source, +4 the destination, +8 the next pointer, and +12 the byte count. A segment never starts before all four words are accepted.
- R5: Bit 0 of the next pointer set means the current descriptor is last. The chain then ends after its segment and no further read is issued. Otherwise the next descriptor is fetched from the pointer with bits 4:0 cleared.
- R6: seg_snoop of a chained segment equals bit 1 of the pointer that led to its descriptor. For the first descriptor this is cfg_desc_ptr bit 1. A direct segment uses cfg_snoop.
- R7: Every accepted beat of b bytes lowers seg_rem by b and raises both seg_src and seg_dst by b.
- R8: Clearing start while busy halts the channel one clock later, with busy and seg_run at 0 and no flag set. A beat or read word offered in the halting cycle is not accepted.
- R9: An err_in pulse while busy halts the channel one clock later and sets error. The error takes priority over any beat, read word or segment end in that cycle.
- R10: done and error are never set together. Each stays set until the next launch, and the launch clears it.
- R11: A launch with resume=1 from a halted state continues where the channel stopped. After a halt during a segment, it keeps seg_src, seg_dst, seg_rem and the snoop flag and issues no descriptor read. After a halt during a fetch, it reads the current descriptor again from word 0.
- R12: A launch with resume=0, or any launch from the idle state, discards the interrupted context and starts fresh from the configuration.
- R13: A chained descriptor with a byte count of 0 is skipped and seg_run does not rise for it. If that descriptor is marked last, done is set after its fourth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Channel-start level: a rising edge launches, clearing halts |
| resume | input | 1 | At launch from a halt: 1 continues, 0 starts fresh |
| chain_mode | input | 1 | At launch: 1 chaining, 0 direct |
| cfg_src | input | 32 | Direct-mode source address |
| cfg_dst | input | 32 | Direct-mode destination address |
| cfg_count | input | CW | Direct-mode byte count |
| cfg_snoop | input | 1 | Direct-mode snoop flag |
| cfg_desc_ptr | input | 32 | First descriptor pointer, bit 1 is its snoop flag |
| err_in | input | 1 | Error report from the transfer path |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_valid | input | 1 | Read data returned for the current request |
| rd_data | input | 32 | Read data |
| seg_run | output | 1 | Segment engine may move data |
| seg_src | output | 32 | Current source address |
| seg_dst | output | 32 | Current destination address |
| seg_rem | output | CW | Bytes left in the segment |
| seg_snoop | output | 1 | Snoop flag of the running segment |
| mv_valid | input | 1 | Engine committed a beat |
| mv_bytes | input | BW | Size of that beat, at most seg_rem |
| busy | output | 1 | Channel is fetching or running |
| done | output | 1 | Transfer finished, sticky |
| error | output | 1 | Channel stopped on error, sticky |

## Verification
Every result arrives one clock after its cause, because every output is a register. A launch shows busy, plus rd_req or seg_run, one edge after start rises. A read word or a beat is accepted on the edge where it is offered, so seg_rem, seg_src and seg_dst have moved by the next falling edge. done, error and halts likewise appear on the edge after the completing beat, the err_in pulse or the start clear. A chained segment begins two edges after its fourth word.

The bench drives inputs and samples outputs on falling edges. It tallies accepted beats and read words on rising edges, applying the same halt qualification the requirements give, so it always compares against a state that has fully settled. Chain lengths, count patterns, beat sizes and read stalls are swept. Halts are placed mid-segment and mid-fetch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int AW          = 32;
  localparam int DESC_WORDS  = 4;
  localparam int FLAG_BITS   = 5;
  localparam int LAST_BIT    = 0;
  localparam int SNOOP_BIT   = 1;
  localparam int IDX_W       = $clog2(DESC_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_e;

  // strip the flag field from a pointer word
  function automatic logic [AW-1:0] ptr_base(input logic [AW-1:0] p);
    return p & ~((AW'(1) << FLAG_BITS) - AW'(1));
  endfunction

  // byte address of descriptor word idx
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                              input logic [IDX_W-1:0] idx);
    return ptr_base(base) + (AW'(idx) << 2);
  endfunction

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  logic [AW-1:0] base,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_data,
  output logic          fetch_done,
  output logic [AW-1:0] d_src,
  output logic [AW-1:0] d_dst,
  output logic [AW-1:0] d_next,
  output logic [AW-1:0] d_cnt
);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic [AW-1:0]    word_q [DESC_WORDS];
  logic             take;
  logic             last_word;

  assign take      = active_q && rd_valid && !abort;
  assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= take && last_word;
      if (abort) begin
        active_q <= 1'b0;
      end else if (go) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (take) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last_word) active_q <= 1'b0;
      end
    end
  end

  for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word_q[w] <= '0;
      else if (take && idx_q == IDX_W'(w))    word_q[w] <= rd_data;
    end
  end

  assign rd_req     = active_q;
  assign rd_addr    = word_addr(base, idx_q);
  assign fetch_done = done_q;
  assign d_src      = word_q[0];
  assign d_dst      = word_q[1];
  assign d_next     = word_q[2];
  assign d_cnt      = word_q[3];

  // R4: words are requested in ascending order, one word apart
  a_r4_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !go && !last_word) |=> (rd_req && rd_addr == $past(rd_addr) + AW'(4)));

  // R4: a descriptor is complete only after its fourth word
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_done) |-> $past(rd_req && rd_addr[3:2] == 2'd3));

endmodule

// File: rtl/dma_seg_track.sv
module dma_seg_track
  import dma_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          beat,
  input  logic [BW-1:0] beat_bytes,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] rem,
  output logic          seg_end
);

  function automatic logic [CW-1:0] rem_after(input logic [CW-1:0] r,
                                              input logic [BW-1:0] b);
    return r - CW'(b);
  endfunction

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a,
                                               input logic [BW-1:0] b);
    return a + AW'(b);
  endfunction

  assign seg_end = beat && (rem_after(rem, beat_bytes) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      rem <= '0;
    end else if (load) begin
      src <= ld_src;
      dst <= ld_dst;
      rem <= ld_cnt;
    end else if (beat) begin
      src <= addr_after(src, beat_bytes);
      dst <= addr_after(dst, beat_bytes);
      rem <= rem_after(rem, beat_bytes);
    end
  end

  // R7: address advance matches the count consumed
  a_r7_addr_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load) |=> ((src - $past(src)) == AW'($past(rem) - rem)
                         && (dst - $past(dst)) == AW'($past(rem) - rem)));

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          resume,
  input  logic          chain_mode,
  input  logic [31:0]   cfg_src,
  input  logic [31:0]   cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_snoop,
  input  logic [31:0]   cfg_desc_ptr,
  input  logic          err_in,
  output logic          rd_req,
  output logic [31:0]   rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          seg_run,
  output logic [31:0]   seg_src,
  output logic [31:0]   seg_dst,
  output logic [CW-1:0] seg_rem,
  output logic          seg_snoop,
  input  logic          mv_valid,
  input  logic [BW-1:0] mv_bytes,
  output logic          busy,
  output logic          done,
  output logic          error
);

  seq_state_e    state_q;
  logic          start_q;
  logic          done_q, err_q;
  logic [AW-1:0] cur_ptr_q, nxt_ptr_q;
  logic          cur_snoop_q, nxt_snoop_q, last_q;
  logic          halt_in_fetch_q;

  // named internal events
  logic          start_rise, launch, resume_ok, fresh;
  logic          active, halt_ev, err_ev;
  logic          beat_ok, seg_end, fetch_done;
  logic          d_zero, d_last, fetch_go, trk_load;
  logic [AW-1:0] d_src, d_dst, d_next, d_cnt_w;
  logic [CW-1:0] d_cnt;

  assign start_rise = start && !start_q;
  assign launch     = start_rise && (state_q == ST_IDLE || state_q == ST_HALT);
  assign resume_ok  = launch && resume && (state_q == ST_HALT);
  assign fresh      = launch && !resume_ok;
  assign active     = (state_q == ST_FETCH) || (state_q == ST_RUN);
  assign err_ev     = active && err_in;
  assign halt_ev    = active && (err_in || !start);
  assign beat_ok    = (state_q == ST_RUN) && mv_valid && !halt_ev;

  assign d_cnt  = CW'(d_cnt_w);
  assign d_zero = (d_cnt == '0);
  assign d_last = d_next[LAST_BIT];

  logic fd_ok;
  assign fd_ok = (state_q == ST_FETCH) && fetch_done && !halt_ev;

  assign fetch_go = (fresh && chain_mode)
                 || (resume_ok && halt_in_fetch_q)
                 || (fd_ok && d_zero && !d_last)
                 || ((state_q == ST_RUN) && seg_end && !halt_ev && !last_q);

  assign trk_load = (fresh && !chain_mode && cfg_count != '0)
                 || (fd_ok && !d_zero);

  dma_desc_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .abort      (halt_ev),
    .base       (cur_ptr_q),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fetch_done (fetch_done),
    .d_src      (d_src),
    .d_dst      (d_dst),
    .d_next     (d_next),
    .d_cnt      (d_cnt_w)
  );

  dma_seg_track #(.CW(CW), .BW(BW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (trk_load),
    .ld_src     ((state_q == ST_FETCH) ? d_src : cfg_src),
    .ld_dst     ((state_q == ST_FETCH) ? d_dst : cfg_dst),
    .ld_cnt     ((state_q == ST_FETCH) ? d_cnt : cfg_count),
    .beat       (beat_ok),
    .beat_bytes (mv_bytes),
    .src        (seg_src),
    .dst        (seg_dst),
    .rem        (seg_rem),
    .seg_end    (seg_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= ST_IDLE;
      start_q         <= 1'b0;
      done_q          <= 1'b0;
      err_q           <= 1'b0;
      cur_ptr_q       <= '0;
      nxt_ptr_q       <= '0;
      cur_snoop_q     <= 1'b0;
      nxt_snoop_q     <= 1'b0;
      last_q          <= 1'b0;
      halt_in_fetch_q <= 1'b0;
    end else begin
      start_q <= start;
      if (launch) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (resume_ok) begin
            state_q <= halt_in_fetch_q ? ST_FETCH : ST_RUN;
          end else if (fresh && !chain_mode) begin
            last_q      <= 1'b1;
            cur_snoop_q <= cfg_snoop;
            if (cfg_count == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_RUN;
            end
          end else if (fresh) begin
            cur_ptr_q   <= ptr_base(cfg_desc_ptr);
            cur_snoop_q <= cfg_desc_ptr[SNOOP_BIT];
            state_q     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (halt_ev) begin
            state_q         <= ST_HALT;
            halt_in_fetch_q <= 1'b1;
            if (err_ev) err_q <= 1'b1;
          end else if (fetch_done) begin
            if (d_zero && d_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (d_zero) begin
              cur_ptr_q   <= ptr_base(d_next);
              cur_snoop_q <= d_next[SNOOP_BIT];
            end else begin
              nxt_ptr_q   <= ptr_base(d_next);
              nxt_snoop_q <= d_next[SNOOP_BIT];
              last_q      <= d_last;
              state_q     <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (halt_ev) begin
            state_q         <= ST_HALT;
            halt_in_fetch_q <= 1'b0;
            if (err_ev) err_q <= 1'b1;
          end else if (seg_end) begin
            if (last_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cur_ptr_q   <= nxt_ptr_q;
              cur_snoop_q <= nxt_snoop_q;
              state_q     <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign seg_run   = (state_q == ST_RUN);
  assign seg_snoop = cur_snoop_q;
  assign busy      = active;
  assign done      = done_q;
  assign error     = err_q;

  // R8: clearing start while busy stops the channel on the next edge
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!busy && !seg_run && !rd_req));

  // R9: an error report while busy halts and flags
  a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_in) |=> (error && !busy && !done));

  // R10: flags are exclusive
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R10: done stays until a launch
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_rise) |=> done);

  // R10: error stays until a launch
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start_rise) |=> error);

  // R3: a running segment always has bytes left
  a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seg_run |-> (seg_rem != '0));

  // R7: the engine never reports more than is left
  a_r7_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_run && mv_valid) |-> (CW'(mv_bytes) <= seg_rem));

  // R3: done rises only on the edge after the channel was busy or launched
  a_r3_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy || start_rise));

endmodule

// File: tb/test_dma_chain_seq.sv
`timescale 1ns/1ps
module test_dma_chain_seq;

  localparam int CW = 16;
  localparam int BW = 8;
  localparam logic [31:0] DBASE = 32'h0000_4000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, resume, chain_mode, cfg_snoop, err_in;
  logic [31:0]   cfg_src, cfg_dst, cfg_desc_ptr;
  logic [CW-1:0] cfg_count;
  logic          rd_req, rd_valid;
  logic [31:0]   rd_addr, rd_data;
  logic          seg_run, seg_snoop, mv_valid;
  logic [31:0]   seg_src, seg_dst;
  logic [CW-1:0] seg_rem;
  logic [BW-1:0] mv_bytes;
  logic          busy, done, error;

  always #10 clk = ~clk;

  dma_chain_seq #(.CW(CW), .BW(BW)) i_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
    .chain_mode(chain_mode), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_snoop(cfg_snoop), .cfg_desc_ptr(cfg_desc_ptr),
    .err_in(err_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .seg_run(seg_run), .seg_src(seg_src), .seg_dst(seg_dst),
    .seg_rem(seg_rem), .seg_snoop(seg_snoop), .mv_valid(mv_valid),
    .mv_bytes(mv_bytes), .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errors = 0, cyc = 0, ncyc = 0;
  int tb_len = 1, tb_seed = 0, tb_chunk = 1, tb_gap = 0;
  logic tb_chain = 1'b0, resuming = 1'b0, run_prev = 1'b0;
  int moved = 0, segs = 0, rd_acc = 0, exp_fi = 0, exp_seg = -1;
  logic [31:0] exp_addr = '0;
  logic [31:0] s_src0 = '0, s_dst0 = '0, sv_src = '0, sv_dst = '0;
  int s_cnt0 = 0, sv_rem = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dbase(input int i); return DBASE + 32'(i) * 32; endfunction
  function automatic logic [31:0] x_src(input int i); return 32'h1000_0000 + 32'(i) * 32'h120 + 32'(i % 4); endfunction
  function automatic logic [31:0] x_dst(input int i); return 32'h2000_0000 + 32'(i) * 32'h80 + 32'((i + 1) % 4); endfunction
  function automatic int x_cnt(input int i); return ((i * 5 + tb_seed) % 6) * 4 + (i % 3); endfunction
  function automatic logic x_snp(input int i); return 1'((i + tb_seed) & 1); endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int i;
    i = int'((a - DBASE) >> 5);
    case (a[3:2])
      2'd0:    return x_src(i);
      2'd1:    return x_dst(i);
      2'd2:    return dbase(i + 1) | 32'h14 | {30'd0, x_snp(i + 1), 1'b0}
                      | {31'd0, i == tb_len - 1};
      default: return 32'h00AB_0000 | 32'(x_cnt(i));
    endcase
  endfunction

  function automatic int sum_cnt(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += x_cnt(i);
    return s;
  endfunction

  function automatic int nz_cnt(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) if (x_cnt(i) != 0) s++;
    return s;
  endfunction

  // memory and segment engine models, segment monitor
  always @(negedge clk) begin
    ncyc++;
    rd_valid = rd_req && ((ncyc % (tb_gap + 1)) == 0);
    rd_data  = mem_word(rd_addr);
    mv_valid = seg_run && ((ncyc % (tb_gap + 1)) == 0);
    mv_bytes = (int'(seg_rem) < tb_chunk) ? BW'(seg_rem) : BW'(tb_chunk);
    if (rst_n && seg_run && !run_prev) begin
      if (resuming) begin
        chk(seg_src == sv_src && seg_dst == sv_dst && int'(seg_rem) == sv_rem,
            "R11 resume keeps segment", seg_rem, sv_rem);
        resuming = 1'b0;
      end else if (tb_chain) begin
        int i;
        i = exp_seg + 1;
        while (i < tb_len && x_cnt(i) == 0) i++;
        chk(seg_src == x_src(i), "R4 seg src", seg_src, x_src(i));
        chk(seg_dst == x_dst(i), "R4 seg dst", seg_dst, x_dst(i));
        chk(int'(seg_rem) == x_cnt(i), "R13 seg count skips zero", seg_rem, x_cnt(i));
        chk(seg_snoop == x_snp(i), "R6 seg snoop", seg_snoop, x_snp(i));
        exp_seg = i;
        s_src0 = seg_src; s_dst0 = seg_dst; s_cnt0 = int'(seg_rem); segs++;
      end else begin
        chk(seg_src == cfg_src && seg_dst == cfg_dst && seg_rem == cfg_count,
            "R2 direct seg fields", seg_rem, cfg_count);
        chk(seg_snoop == cfg_snoop, "R6 direct snoop", seg_snoop, cfg_snoop);
        s_src0 = seg_src; s_dst0 = seg_dst; s_cnt0 = int'(seg_rem); segs++;
      end
    end
    if (rst_n && seg_run)
      chk(seg_src - s_src0 == 32'(s_cnt0 - int'(seg_rem))
          && seg_dst - s_dst0 == 32'(s_cnt0 - int'(seg_rem)),
          "R7 address advance", seg_src - s_src0, s_cnt0 - int'(seg_rem));
    run_prev = seg_run;
  end

  // accepted beats and read words
  always @(posedge clk) begin
    cyc++;
    if (rst_n && start && !err_in) begin
      if (seg_run && mv_valid) moved += int'(mv_bytes);
      if (rd_req && rd_valid) begin
        rd_acc++;
        chk(rd_addr == exp_addr, "R4 R5 read order", rd_addr, exp_addr);
        if (exp_addr[3:2] == 2'd3) begin
          exp_fi++;
          exp_addr = dbase(exp_fi);
        end else exp_addr = exp_addr + 4;
      end
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clear_tally();
    moved = 0; segs = 0; rd_acc = 0; exp_fi = 0; exp_seg = -1; exp_addr = dbase(0);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done && !busy && !error, req, {done, busy, error}, 3'b100);
  endtask

  task automatic launch_chain(input int len, input int seed, input int chunk, input int gap);
    tb_len = len; tb_seed = seed; tb_chunk = chunk; tb_gap = gap; tb_chain = 1'b1;
    clear_tally();
    chain_mode = 1'b1;
    cfg_desc_ptr = dbase(0) | 32'h09 | {30'd0, x_snp(0), 1'b0};
    start = 1'b1;
    @(negedge clk);
    chk(busy && rd_req && rd_addr == dbase(0), "R2 chain launch", rd_addr, dbase(0));
  endtask

  task automatic run_chain(input int len, input int seed, input int chunk, input int gap);
    launch_chain(len, seed, chunk, gap);
    wait_done("R5 chain ends at last");
    chk(moved == sum_cnt(len), "R3 chain bytes", moved, sum_cnt(len));
    chk(segs == nz_cnt(len), "R13 segment count", segs, nz_cnt(len));
    chk(rd_acc == 4 * len, "R5 no read past last", rd_acc, 4 * len);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_direct(input int cnt, input logic snp, input int chunk, input logic res);
    tb_chain = 1'b0; tb_chunk = chunk; tb_gap = 0; clear_tally();
    chain_mode = 1'b0; resume = res;
    cfg_src = 32'h3000_0001 + 32'(cnt); cfg_dst = 32'h5000_0002 + 32'(cnt * 3);
    cfg_count = CW'(cnt); cfg_snoop = snp;
    start = 1'b1;
    @(negedge clk);
    if (cnt == 0) begin
      chk(done && !seg_run && !busy, "R3 zero count done", {done, seg_run}, 2'b10);
    end else begin
      chk(seg_run && busy, "R2 direct launch R12", seg_run, 1);
      wait_done("R3 direct completes");
    end
    chk(moved == cnt, "R3 direct bytes", moved, cnt);
    chk(rd_acc == 0, "R2 direct no reads", rd_acc, 0);
    start = 1'b0; resume = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; resume = 1'b0; chain_mode = 1'b0; err_in = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_count = '0; cfg_snoop = 1'b0; cfg_desc_ptr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !rd_req && !seg_run, "R1 reset state",
        {busy, done, error, rd_req, seg_run}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !rd_req && !seg_run, "R1 after reset",
        {busy, done, error, rd_req, seg_run}, 0);

    // direct mode sweep
    for (int c = 0; c < 4; c++)
      for (int k = 1; k <= 3; k++)
        run_direct((c == 0) ? 0 : c * 7 - 2, 1'(k & 1), k, 1'b0);

    // chaining sweep over length, count pattern, beat size and read stalls
    for (int len = 1; len <= 4; len++)
      for (int seed = 0; seed < 3; seed++)
        for (int chunk = 1; chunk <= 3; chunk++)
          run_chain(len, seed, chunk, (len + seed) % 2);

    // R10: done sticks after start falls
    repeat (3) @(negedge clk);
    chk(done && !error, "R10 done sticky", {done, error}, 2'b10);

    // R8 and R11: halt mid-segment, then resume
    launch_chain(3, 1, 1, 0);
    chk(!done, "R10 launch clears done", done, 0);
    while (!(seg_run && moved >= 2)) @(negedge clk);
    sv_rem = int'(seg_rem); sv_src = seg_src; sv_dst = seg_dst;
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !seg_run && !done && !error, "R8 stop halts", {busy, seg_run, done, error}, 0);
    chk(int'(seg_rem) == sv_rem, "R8 halting beat ignored", seg_rem, sv_rem);
    repeat (2) @(negedge clk);
    resuming = 1'b1; resume = 1'b1; start = 1'b1;
    @(negedge clk);
    chk(seg_run && busy && !rd_req, "R11 resume runs without fetch", {seg_run, rd_req}, 2'b10);
    wait_done("R11 resumed chain completes");
    chk(moved == sum_cnt(3), "R11 resumed bytes", moved, sum_cnt(3));
    chk(rd_acc == 12, "R11 no refetch", rd_acc, 12);
    start = 1'b0; resume = 1'b0;
    @(negedge clk);

    // R8 and R11: halt during a fetch, then resume re-reads from word 0
    launch_chain(2, 1, 2, 0);
    while (!(rd_req && exp_addr[3:2] == 2'd2)) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req && !error, "R8 halt in fetch", {busy, rd_req}, 0);
    exp_addr = dbase(exp_fi);
    resume = 1'b1; start = 1'b1;
    @(negedge clk);
    chk(rd_req && rd_addr == dbase(0), "R11 refetch word 0", rd_addr, dbase(0));
    wait_done("R11 fetch resume completes");
    chk(rd_acc == 10, "R11 refetch count", rd_acc, 10);
    chk(moved == sum_cnt(2), "R11 fetch resume bytes", moved, sum_cnt(2));
    start = 1'b0; resume = 1'b0;
    @(negedge clk);

    // R9, R10, R12: error halt, then reconfigure
    launch_chain(3, 2, 1, 0);
    while (!(seg_run && moved >= 1)) @(negedge clk);
    sv_rem = int'(seg_rem);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    chk(error && !busy && !done && !seg_run, "R9 error halts", {error, busy, done}, 3'b100);
    chk(int'(seg_rem) == sv_rem, "R9 beat dropped on error", seg_rem, sv_rem);
    repeat (3) @(negedge clk);
    chk(error && !done, "R10 error sticky", error, 1);
    start = 1'b0;
    @(negedge clk);
    run_direct(9, 1'b1, 2, 1'b0);
    chk(!error, "R10 launch clears error", error, 0);

    // R12: resume=1 from idle starts fresh
    run_direct(5, 1'b0, 1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule